// File: doc/BRIEF.md
# Hash Core Message Interface Controller

This block is the active I/O controller of a block-oriented hash core. Two passive FIFOs sit around it. It pulls words from the input FIFO, using the FIFO's empty flag and a pop strobe. It pushes digest words into the output FIFO, using the FIFO's full flag and a push strobe. The input stream is a sequence of messages. Each message opens with one word that gives its length in bits, and that word is followed by the message words. The controller counts the remaining bits itself, so the stream carries no end-of-message marker.

Message words are packed into fixed-size blocks held in two alternating buffers. A placeholder mixing datapath runs a fixed number of rounds on each block and chains its state across the blocks of one message. When the last block of a message is done, the chained state is handed to an output stage as the digest. Three activities overlap:

- loading the next block into the free buffer;
- mixing the current block;
- writing out the previous message's digest.

Full rate holds when loading a block takes no longer than mixing one.

Top module: `hci_core`

## Requirements
- R1: While reset is high, neither strobe is asserted. After reset, no pop is issued while the input FIFO reports empty.
- R2: A pop is issued only in a cycle where the input FIFO is not empty. The popped word is taken from the FIFO data port in the cycle after the pop.
- R3: A push is issued only in a cycle where the output FIFO is not full.
- R4: The first word of each message is its length L in bits. The message then consumes exactly ceil(L/32) further words, and the last of them is used whole. The following word is the next message's length.
- R5: Message words are packed four per 128-bit block. The first word of a block sits in bits 127:96 and the fourth in bits 31:0. Positions left over in a message's final block are zero, giving ceil(words/4) blocks.
- R6: The 64-bit chain state starts at 0x0123456789ABCDEF for every message. Each block applies 4 rounds, numbered r = 0..3. Each round rotates the state left by one bit, then XORs in the block's upper half, its lower half and r.
- R7: Each message yields a digest of two 32-bit words, the upper half first. The digests leave in message order, and a word waiting on a full output FIFO is held unchanged.
- R8: A message of length zero consumes only its length word and yields exactly one digest, equal to the initial state.
- R9: Pops stop when both block buffers are occupied. The mixer cannot take its next block while an unsent digest is pending. With the output FIFO held full from the start, a stream of 32-bit messages therefore has exactly 6 words popped.
- R10: Block loading overlaps mixing. A 1024-bit message with free-flowing FIFOs takes at most 64 cycles from its length pop to its last digest push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 32 | Input FIFO read data |
| rx_empty | input | 1 | Input FIFO empty flag |
| rx_pop | output | 1 | Input FIFO read strobe |
| tx_data | output | 32 | Output FIFO write data |
| tx_full | input | 1 | Output FIFO full flag |
| tx_push | output | 1 | Output FIFO write strobe |

## Verification
The table of messages varies the length so that each case is separated from its neighbours:

- a single word;
- an exact block;
- one word past a block boundary;
- a length that is not a word multiple;
- a zero length in the middle of the stream;
- two full blocks.

Together these show whether the word counting, the zero fill and the chaining across blocks are right. Directed runs add:

- back-to-back zero-length messages, which show a missing or doubled digest;
- an output FIFO held full, where the exact pop count exposes wrong stall logic in the double buffer;
- a long message timed end to end, which tells overlapped loading from serial loading;
- toggling empty and full flags, which shows handshake slips.

// File: rtl/hci_pkg.sv
package hci_pkg;

    parameter int unsigned WORD_W    = 32;
    parameter int unsigned BLK_WORDS = 4;
    parameter int unsigned DIG_WORDS = 2;
    parameter int unsigned ROUNDS    = 4;

    localparam int unsigned BLK_W  = WORD_W * BLK_WORDS;
    localparam int unsigned DIG_W  = WORD_W * DIG_WORDS;
    localparam int unsigned FOLD_N = BLK_W / DIG_W;
    localparam int unsigned WIDX_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
    localparam int unsigned RCNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam int unsigned OIDX_W = (DIG_WORDS > 1) ? $clog2(DIG_WORDS) : 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [DIG_W-1:0]  dig_t;
    typedef logic [WIDX_W-1:0] widx_t;
    typedef logic [RCNT_W-1:0] rcnt_t;
    typedef logic [OIDX_W-1:0] oidx_t;

    localparam dig_t  DIG_IV    = dig_t'(64'h0123_4567_89AB_CDEF);
    localparam word_t W_BITS    = word_t'(WORD_W);
    localparam widx_t WIDX_LAST = widx_t'(BLK_WORDS - 1);
    localparam rcnt_t RCNT_LAST = rcnt_t'(ROUNDS - 1);
    localparam oidx_t OIDX_LAST = oidx_t'(DIG_WORDS - 1);

    typedef enum logic {LD_LEN, LD_DATA} ld_state_e;
    typedef enum logic {MX_IDLE, MX_RUN} mx_state_e;

    // metadata carried with each filled buffer
    typedef struct packed {
        logic last;   // final block of its message
        logic empty;  // zero-length message, no data to mix
    } tag_t;

    function automatic dig_t fold_block(blk_t b);
        dig_t f;
        f = '0;
        for (int unsigned i = 0; i < FOLD_N; i++) begin
            f = f ^ b[i*DIG_W +: DIG_W];
        end
        return f;
    endfunction

    function automatic dig_t mix_round(dig_t s, blk_t b, rcnt_t r);
        return {s[DIG_W-2:0], s[DIG_W-1]} ^ fold_block(b) ^ dig_t'(r);
    endfunction

endpackage

// File: rtl/hci_blockbuf.sv
module hci_blockbuf
    import hci_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  widx_t      wr_idx,
    input  word_t      wr_data,
    input  logic       close_en,
    input  tag_t       close_tag,
    input  logic       rel_en,
    input  logic       rd_sel,
    output logic [1:0] valid,
    output tag_t       rd_tag,
    output blk_t       rd_blk
);

    blk_t mem  [2];
    tag_t tags [2];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            for (int g = 0; g < 2; g++) begin
                mem[g]  <= '0;
                tags[g] <= '0;
            end
        end else begin
            for (int g = 0; g < 2; g++) begin
                if (wr_en && (int'(wr_sel) == g)) begin
                    if (wr_idx == '0) begin
                        mem[g] <= blk_t'(wr_data) << ((BLK_WORDS - 1) * WORD_W);
                    end else begin
                        mem[g][(BLK_WORDS - 1 - int'(wr_idx)) * WORD_W +: WORD_W] <= wr_data;
                    end
                end
                if (close_en && (int'(wr_sel) == g)) begin
                    valid[g] <= 1'b1;
                    tags[g]  <= close_tag;
                end
                if (rel_en && (int'(rd_sel) == g)) begin
                    valid[g] <= 1'b0;
                end
            end
        end
    end

    assign rd_tag = tags[rd_sel];
    assign rd_blk = mem[rd_sel];

    // R9: the loader never writes or closes a buffer the mixer still owns
    a_r9_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        (wr_en || close_en) |-> !valid[wr_sel]);

    // R6: the mixer only retires a buffer that holds a block
    a_r6_release_valid: assert property (@(posedge clk) disable iff (rst)
        rel_en |-> valid[rd_sel]);

endmodule

// File: rtl/hci_loader.sv
module hci_loader
    import hci_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  word_t      rx_data,
    input  logic       rx_empty,
    output logic       rx_pop,
    input  logic [1:0] buf_valid,
    output logic       wr_en,
    output logic       wr_sel,
    output widx_t      wr_idx,
    output word_t      wr_data,
    output logic       close_en,
    output tag_t       close_tag
);

    ld_state_e st;
    logic      rd_q;      // a popped word is on rx_data this cycle
    logic      fill_sel;
    widx_t     widx;
    word_t     bits_left;

    logic is_len;
    logic last_word;
    logic closes;

    always_comb begin
        is_len    = (st == LD_LEN);
        last_word = (bits_left <= W_BITS);
        closes    = rd_q && (is_len ? (rx_data == '0)
                                    : (last_word || (widx == WIDX_LAST)));
        wr_en     = rd_q && !is_len;
        wr_sel    = fill_sel;
        wr_idx    = widx;
        wr_data   = rx_data;
        close_en  = closes;
        close_tag.last  = is_len ? 1'b1 : last_word;
        close_tag.empty = is_len;
        // the word popped now lands in fill_sel, or in the other buffer if
        // the word arriving now closes fill_sel
        rx_pop = !rst && !rx_empty && !buf_valid[fill_sel]
                 && !(closes && buf_valid[~fill_sel]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= LD_LEN;
            rd_q      <= 1'b0;
            fill_sel  <= 1'b0;
            widx      <= '0;
            bits_left <= '0;
        end else begin
            rd_q <= rx_pop;
            if (rd_q) begin
                if (is_len) begin
                    bits_left <= rx_data;
                    widx      <= '0;
                    if (rx_data != '0) st <= LD_DATA;
                end else begin
                    bits_left <= last_word ? '0 : (bits_left - W_BITS);
                    widx      <= closes ? '0 : (widx + widx_t'(1));
                    if (last_word) st <= LD_LEN;
                end
            end
            if (closes) fill_sel <= ~fill_sel;
        end
    end

    // R8: a zero length word turns into a ready buffer on the next cycle
    a_r8_null_entry: assert property (@(posedge clk) disable iff (rst)
        (rd_q && (st == LD_LEN) && (rx_data == '0)) |=> buf_valid[$past(fill_sel)]);

    // R4: data words are only taken while a message is open
    a_r4_data_in_message: assert property (@(posedge clk) disable iff (rst)
        (rd_q && (st == LD_DATA)) |-> (bits_left != '0));

endmodule

// File: rtl/hci_mixer.sv
module hci_mixer
    import hci_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] buf_valid,
    input  tag_t       rd_tag,
    input  blk_t       rd_blk,
    output logic       rd_sel,
    output logic       rel_en,
    input  logic       emit_busy,
    output logic       emit_load,
    output dig_t       emit_digest
);

    mx_state_e st;
    logic      ptr;
    rcnt_t     rcnt;
    dig_t      chain;

    logic ready;
    logic null_go;
    logic last_round;
    dig_t nxt;

    always_comb begin
        rd_sel      = ptr;
        ready       = buf_valid[ptr] && !(rd_tag.last && emit_busy);
        nxt         = mix_round(chain, rd_blk, rcnt);
        null_go     = (st == MX_IDLE) && ready && rd_tag.empty;
        last_round  = (st == MX_RUN) && (rcnt == RCNT_LAST);
        rel_en      = null_go || last_round;      // one-cycle done pulse
        emit_load   = rel_en && rd_tag.last;
        emit_digest = null_go ? chain : nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= MX_IDLE;
            ptr   <= 1'b0;
            rcnt  <= '0;
            chain <= DIG_IV;
        end else begin
            case (st)
                MX_IDLE: begin
                    if (ready && !rd_tag.empty) begin
                        st   <= MX_RUN;
                        rcnt <= '0;
                    end
                end
                MX_RUN: begin
                    chain <= nxt;
                    rcnt  <= rcnt + rcnt_t'(1);
                    if (last_round) begin
                        st <= MX_IDLE;
                        if (rd_tag.last) chain <= DIG_IV;
                    end
                end
                default: st <= MX_IDLE;
            endcase
            if (rel_en) ptr <= ~ptr;
        end
    end

    // R7: a digest is handed over only when the output stage is free
    a_r7_load_idle_emitter: assert property (@(posedge clk) disable iff (rst)
        emit_load |-> !emit_busy);

    // R6: a block run always begins from idle with a held buffer
    a_r6_run_entry: assert property (@(posedge clk) disable iff (rst)
        ((st == MX_RUN) && (rcnt == '0)) |-> (($past(st) == MX_IDLE) && buf_valid[ptr]));

endmodule

// File: rtl/hci_emitter.sv
module hci_emitter
    import hci_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  dig_t  digest,
    input  logic  tx_full,
    output logic  tx_push,
    output word_t tx_data,
    output logic  busy
);

    dig_t  dig_q;
    oidx_t idx;

    always_comb begin
        tx_push = busy && !tx_full;
        tx_data = dig_q[(DIG_WORDS - 1 - int'(idx)) * WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            idx   <= '0;
            dig_q <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            idx   <= '0;
            dig_q <= digest;
        end else if (tx_push) begin
            if (idx == OIDX_LAST) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + oidx_t'(1);
            end
        end
    end

    // R7: a word stalled by a full output FIFO is held
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (busy && tx_full) |=> ($stable(tx_data) && busy));

    // R3: no push outside an active digest transfer
    a_r3_push_in_transfer: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(load) && (idx == '0)));

endmodule

// File: rtl/hci_core.sv
module hci_core
    import hci_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] rx_data,
    input  logic        rx_empty,
    output logic        rx_pop,
    output logic [31:0] tx_data,
    input  logic        tx_full,
    output logic        tx_push
);

    logic       wr_en;
    logic       wr_sel;
    widx_t      wr_idx;
    word_t      wr_data;
    logic       close_en;
    tag_t       close_tag;
    logic       rel_en;
    logic       rd_sel;
    logic [1:0] buf_valid;
    tag_t       rd_tag;
    blk_t       rd_blk;
    logic       emit_busy;
    logic       emit_load;
    dig_t       emit_digest;

    hci_loader u_loader (
        .clk       (clk),
        .rst       (rst),
        .rx_data   (rx_data),
        .rx_empty  (rx_empty),
        .rx_pop    (rx_pop),
        .buf_valid (buf_valid),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .close_en  (close_en),
        .close_tag (close_tag)
    );

    hci_blockbuf u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .close_en  (close_en),
        .close_tag (close_tag),
        .rel_en    (rel_en),
        .rd_sel    (rd_sel),
        .valid     (buf_valid),
        .rd_tag    (rd_tag),
        .rd_blk    (rd_blk)
    );

    hci_mixer u_mixer (
        .clk         (clk),
        .rst         (rst),
        .buf_valid   (buf_valid),
        .rd_tag      (rd_tag),
        .rd_blk      (rd_blk),
        .rd_sel      (rd_sel),
        .rel_en      (rel_en),
        .emit_busy   (emit_busy),
        .emit_load   (emit_load),
        .emit_digest (emit_digest)
    );

    hci_emitter u_emit (
        .clk     (clk),
        .rst     (rst),
        .load    (emit_load),
        .digest  (emit_digest),
        .tx_full (tx_full),
        .tx_push (tx_push),
        .tx_data (tx_data),
        .busy    (emit_busy)
    );

    // R1: no strobe while reset is applied
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |-> (!rx_pop && !tx_push));

endmodule

// File: tb/test_hci_core.sv
module test_hci_core;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] IV = 64'h0123_4567_89AB_CDEF;

    localparam int NV = 7;
    // stimulus table: length in bits and data seed per message
    localparam int unsigned V_LEN  [NV] = '{32, 128, 160, 40, 0, 256, 97};
    localparam int unsigned V_SEED [NV] = '{11, 12, 13, 14, 15, 16, 17};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rx_data = '0;
    logic        rx_empty;
    logic        rx_pop;
    logic [31:0] tx_data;
    logic        tx_full = 1'b0;
    logic        tx_push;

    logic        starve = 1'b0;
    logic [31:0] in_mem  [256];
    logic [31:0] out_mem [128];
    int          in_wp = 0;
    int          in_rp = 0;
    int          out_wp = 0;
    logic        pop_s = 1'b0;
    logic        push_s = 1'b0;
    logic [31:0] push_d = '0;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int viol_pop = 0;
    int viol_push = 0;
    int pops_in_rst = 0;
    int push_in_rst = 0;
    bit mark_on = 1'b0;
    int first_pop = -1;
    int last_push = -1;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rx_empty = starve || (in_rp == in_wp);

    hci_core i_hci_core (
        .clk      (clk),
        .rst      (rst),
        .rx_data  (rx_data),
        .rx_empty (rx_empty),
        .rx_pop   (rx_pop),
        .tx_data  (tx_data),
        .tx_full  (tx_full),
        .tx_push  (tx_push)
    );

    // strobes sampled mid-cycle, acted on at the following edge
    always @(negedge clk) begin
        pop_s  <= rx_pop;
        push_s <= tx_push;
        push_d <= tx_data;
        if (rst && rx_pop) pops_in_rst++;
        if (rst && tx_push) push_in_rst++;
        if (rx_pop && rx_empty) viol_pop++;
        if (tx_push && tx_full) viol_push++;
        if (mark_on && rx_pop && first_pop < 0) first_pop = cyc;
        if (mark_on && tx_push) last_push = cyc;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pop_s) begin
            rx_data <= in_mem[in_rp];
            in_rp   <= in_rp + 1;
        end
        if (push_s) begin
            out_mem[out_wp] <= push_d;
            out_wp          <= out_wp + 1;
        end
    end

    function automatic logic [31:0] gen_word(int unsigned seed, int unsigned j);
        logic [31:0] a;
        a = seed * 32'h9E37_79B1;
        return a + j * 32'h0101_0101 + 32'h0000_005A;
    endfunction

    function automatic logic [63:0] ref_digest(int unsigned len, int unsigned seed);
        logic [63:0]  s;
        logic [127:0] blk;
        logic [63:0]  f;
        int unsigned  nw;
        int unsigned  nb;
        s  = IV;
        nw = (len + 31) / 32;
        nb = (nw + 3) / 4;
        for (int unsigned b = 0; b < nb; b++) begin
            blk = '0;
            for (int unsigned k = 0; k < 4; k++) begin
                if (b * 4 + k < nw) blk[(3 - k) * 32 +: 32] = gen_word(seed, b * 4 + k);
            end
            f = blk[127:64] ^ blk[63:0];
            for (int unsigned r = 0; r < 4; r++) begin
                s = {s[62:0], s[63]} ^ f ^ 64'(r);
            end
        end
        return s;
    endfunction

    task automatic push_msg(int unsigned len, int unsigned seed);
        in_mem[in_wp] = len;
        in_wp++;
        for (int unsigned j = 0; j < (len + 31) / 32; j++) begin
            in_mem[in_wp] = gen_word(seed, j);
            in_wp++;
        end
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_out(int n, int limit);
        for (int i = 0; i < limit && out_wp < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk_digest(string req, int base, logic [63:0] exp);
        chk(req, {out_mem[base], out_mem[base + 1]}, exp);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!finished) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin : stim
        int base;
        int rp0;
        // load the table stream before reset is released
        for (int v = 0; v < NV; v++) push_msg(V_LEN[v], V_SEED[v]);
        starve = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            #1;
        end
        @(negedge clk);
        chk("R1 pop during reset", 64'(pops_in_rst), 64'd0);
        chk("R1 push during reset", 64'(push_in_rst), 64'd0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            #1;
        end
        chk("R1 no pop while empty", 64'(in_rp), 64'd0);

        // table walk: R4 R5 R6 R7 R8
        starve = 1'b0;
        wait_out(2 * NV, 2000);
        chk("R4 digest count", 64'(out_wp), 64'(2 * NV));
        for (int v = 0; v < NV; v++) begin
            chk($sformatf("R4 R5 R6 R7 vector %0d len %0d", v, V_LEN[v]),
                {out_mem[2 * v], out_mem[2 * v + 1]}, ref_digest(V_LEN[v], V_SEED[v]));
        end
        chk("R8 zero length in table", {out_mem[8], out_mem[9]}, IV);

        // R8: back-to-back zero-length messages
        base = out_wp;
        push_msg(0, 0);
        push_msg(0, 0);
        wait_out(base + 4, 200);
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            #1;
        end
        chk("R8 one digest each", 64'(out_wp - base), 64'd4);
        chk_digest("R8 first zero-length", base, IV);
        chk_digest("R8 second zero-length", base + 2, IV);

        // R9: output held full, stream of one-word messages
        tx_full = 1'b1;
        base = out_wp;
        rp0 = in_rp;
        for (int m = 0; m < 5; m++) push_msg(32, 40 + m);
        for (int i = 0; i < 80; i++) begin
            @(posedge clk);
            #1;
        end
        chk("R9 pops with both buffers held", 64'(in_rp - rp0), 64'd6);
        chk("R3 nothing pushed while full", 64'(out_wp - base), 64'd0);
        tx_full = 1'b0;
        wait_out(base + 10, 500);
        for (int m = 0; m < 5; m++) begin
            chk_digest($sformatf("R7 order after stall msg %0d", m), base + 2 * m,
                       ref_digest(32, 40 + m));
        end

        // R10: overlap of loading and mixing on a 1024-bit message
        base = out_wp;
        mark_on = 1'b1;
        push_msg(1024, 77);
        wait_out(base + 2, 500);
        @(negedge clk);
        mark_on = 1'b0;
        chk_digest("R10 long message digest", base, ref_digest(1024, 77));
        chk("R10 cycles within bound", 64'((last_push - first_pop) <= 64), 64'd1);

        // R2 R3 R7: toggling empty and full flags
        base = out_wp;
        push_msg(256, 91);
        push_msg(72, 92);
        for (int i = 0; i < 400 && out_wp < base + 4; i++) begin
            @(posedge clk);
            #1;
            starve  = cyc[0];
            tx_full = cyc[1] & cyc[0];
        end
        starve  = 1'b0;
        tx_full = 1'b0;
        wait_out(base + 4, 200);
        chk_digest("R7 under flag toggling msg 0", base, ref_digest(256, 91));
        chk_digest("R7 under flag toggling msg 1", base + 2, ref_digest(72, 92));
        chk("R2 pop while empty", 64'(viol_pop), 64'd0);
        chk("R3 push while full", 64'(viol_push), 64'd0);
        chk("R4 input fully consumed", 64'(in_rp), 64'(in_wp));

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule